// File: doc/BRIEF.md
# Serial Bus PHY Gap-Count Controller

This block holds the one PHY register that the link layer may write to change the arbitration gap count, the root-holdoff flag and the bus-reset strobe of a serial bus PHY. Link-side register writes and PHY-config packets can both change these values. A packet changes them whether the node receives it or sends it. The block presents the current gap count and root-holdoff flag to the rest of the PHY. It also gives a one-cycle request that starts a bus reset.

The block counts bus-reset completions that arrive with no gap-count update between them. When the second such reset completes, the gap count falls back to its maximum of 63. Any gap-count update clears this history, whether it comes from a register write or from a packet. A packet can therefore be followed by one verifying bus reset and keep its new value. A write that sets the reset strobe also keeps the gap count it loads through the reset it starts.

Top module: `phy_gap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the gap count is 63, the root-holdoff flag is 0, the reset request is 0, the reset history is empty and the readback value is 8'h3F.
- R2: A register write (`wr_en` high) loads the root-holdoff flag from bit 7 and the gap count from bits 5:0 of `wr_data`. Both values are visible on the cycle after the write, whatever the value of bit 6.
- R3: A register write with bit 6 set drives `bus_reset_req` high for exactly the one cycle that follows the write. A write with bit 6 clear, or any cycle with no write, leaves it low.
- R4: `rd_data` is always {root-holdoff, 0, gap count}. Bit 6 always reads 0.
- R5: A PHY-config packet loads the gap count from `pcfg_gap` when `pcfg_t` is 1, and loads the root-holdoff flag from `pcfg_rhb` when `pcfg_r` is 1. This holds for a received packet (`pcfg_rx_valid`) and for a transmitted one (`pcfg_tx_valid`) alike.
- R6: A packet with `pcfg_t` at 0 leaves the gap count unchanged and does not clear the reset history.
- R7: When a bus reset completes (`brst_done`) and the previous completed reset had no gap-count update after it, the gap count becomes 63 on the next cycle.
- R8: A gap-count update from a write or a packet clears the history. The first reset that completes after it keeps the loaded gap count. This includes the reset that a strobe write itself starts.
- R9: When a gap-count update and `brst_done` arrive in the same cycle, the update is applied and the reset counts as the first one after it. The next reset with no update between then forces 63.
- R10: When a register write and a packet arrive in the same cycle, the write alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the link side |
| wr_data | input | 8 | Write data: [7] root-holdoff, [6] start bus reset, [5:0] gap count |
| rd_data | output | 8 | Register readback value |
| pcfg_rx_valid | input | 1 | A PHY-config packet was received |
| pcfg_tx_valid | input | 1 | A PHY-config packet was transmitted |
| pcfg_r | input | 1 | Packet carries a root-holdoff value |
| pcfg_rhb | input | 1 | Root-holdoff value of the packet |
| pcfg_t | input | 1 | Packet carries a gap count |
| pcfg_gap | input | 6 | Gap-count value of the packet |
| brst_done | input | 1 | One-cycle pulse when a bus reset completes |
| gap_count | output | 6 | Current gap count |
| root_holdoff | output | 1 | Current root-holdoff flag |
| bus_reset_req | output | 1 | One-cycle request to start a bus reset |

## Verification
The assertions assume that `brst_done`, `wr_en` and the two packet strobes are single-cycle event pulses sampled on the clock. They also assume that packet fields are meaningful only while a packet strobe is high. The stimulus drives every event for exactly one cycle, changes inputs only on the falling edge, and leaves the packet fields at arbitrary values when no strobe is high. It deliberately makes events collide: write with packet, update with reset completion, and strobe write with reset completion. These collisions exercise the priority rules that the assertions rely on.

// File: rtl/phy_gap_pkg.sv
// Shared constants and the merged update record for the gap-count controller.
// Assumes a register of 8 bits with fixed positions for the holdoff and strobe bits.
package phy_gap_pkg;
    localparam int GAP_W   = 6;
    localparam int REG_W   = GAP_W + 2;
    localparam int RHB_POS = REG_W - 1;
    localparam int IBR_POS = REG_W - 2;

    typedef struct packed {
        logic             gap_ld;
        logic [GAP_W-1:0] gap;
        logic             rhb_ld;
        logic             rhb;
        logic             ibr;
    } upd_t;
endpackage

// File: rtl/phy_gap_upd_sel.sv
// Merges a link register write and PHY-config packet events into one update record.
// Assumes all inputs are single-cycle events; a write outranks a packet in the same cycle.
module phy_gap_upd_sel
    import phy_gap_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rx_valid,
    input  logic             tx_valid,
    input  logic             r_flag,
    input  logic             r_val,
    input  logic             t_flag,
    input  logic [GAP_W-1:0] t_gap,
    output upd_t             upd
);
    logic pkt;

    // Received and transmitted packets are treated the same way.
    assign pkt = rx_valid | tx_valid;

    // Pick the update source: a write first, then a packet.
    always_comb begin
        upd = '0;
        if (wr_en) begin
            upd.gap_ld = 1'b1;
            upd.gap    = wr_data[GAP_W-1:0];
            upd.rhb_ld = 1'b1;
            upd.rhb    = wr_data[RHB_POS];
            upd.ibr    = wr_data[IBR_POS];
        end else if (pkt) begin
            upd.gap_ld = t_flag;
            upd.gap    = t_gap;
            upd.rhb_ld = r_flag;
            upd.rhb    = r_val;
        end
    end
endmodule

// File: rtl/phy_gap_hist.sv
// Counts completed bus resets since the last gap-count update and flags the
// reset that must restore the maximum gap count.
// Assumes brst_done is a one-cycle pulse; an update in the same cycle is applied first.
module phy_gap_hist #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brst_done,
    input  logic gap_upd,
    output logic force_max
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Restore the maximum when this reset completes the run of bare resets.
    assign force_max = brst_done && !gap_upd && (cnt_q >= LAST);

    // Track the bare resets, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (gap_upd)
            cnt_q <= brst_done ? CW'(1) : '0;
        else if (brst_done && cnt_q != TOP)
            cnt_q <= cnt_q + CW'(1);
    end

    AST_HIST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_upd && brst_done) |=> (cnt_q == CW'(1)));  // R9
    AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_upd && !brst_done) |=> (cnt_q == '0));  // R8
    AST_HIST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        brst_done |=> (cnt_q <= TOP));  // R7
endmodule

// File: rtl/phy_gap_regs.sv
// Holds the gap count, the root-holdoff flag and the reset request register.
// Assumes force_max and a gap load never coincide (the history block ensures this).
module phy_gap_regs
    import phy_gap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  upd_t             upd,
    input  logic             force_max,
    output logic [GAP_W-1:0] gap_q,
    output logic             rhb_q,
    output logic             req_q
);
    // Gap count: restore the maximum, load an update, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '1;
        else if (force_max)
            gap_q <= '1;
        else if (upd.gap_ld)
            gap_q <= upd.gap;
    end

    // Root-holdoff flag: load only on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rhb_q <= 1'b0;
        else if (upd.rhb_ld)
            rhb_q <= upd.rhb;
    end

    // Self-clearing bus-reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= upd.ibr;
    end

    AST_FORCE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        force_max |=> (gap_q == '1));  // R7
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd.gap_ld && !force_max) |=> $stable(gap_q));  // R6
    AST_RHB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd.rhb_ld |=> $stable(rhb_q));  // R5
endmodule

// File: rtl/phy_gap_ctrl.sv
// Top level of the serial bus PHY gap-count controller: register writes, PHY-config
// packet updates, consecutive-reset tracking and readback.
// Assumes every event input is a one-cycle pulse in the clk domain.
module phy_gap_ctrl
    import phy_gap_pkg::*;
#(
    parameter int RESET_LIMIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pcfg_rx_valid,
    input  logic             pcfg_tx_valid,
    input  logic             pcfg_r,
    input  logic             pcfg_rhb,
    input  logic             pcfg_t,
    input  logic [GAP_W-1:0] pcfg_gap,
    input  logic             brst_done,
    output logic [GAP_W-1:0] gap_count,
    output logic             root_holdoff,
    output logic             bus_reset_req
);
    upd_t upd;
    logic force_max;

    phy_gap_upd_sel u_sel (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rx_valid (pcfg_rx_valid),
        .tx_valid (pcfg_tx_valid),
        .r_flag   (pcfg_r),
        .r_val    (pcfg_rhb),
        .t_flag   (pcfg_t),
        .t_gap    (pcfg_gap),
        .upd      (upd)
    );

    phy_gap_hist #(.LIMIT(RESET_LIMIT)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .brst_done (brst_done),
        .gap_upd   (upd.gap_ld),
        .force_max (force_max)
    );

    phy_gap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .force_max (force_max),
        .gap_q     (gap_count),
        .rhb_q     (root_holdoff),
        .req_q     (bus_reset_req)
    );

    // Readback: the strobe bit always reads as zero.
    assign rd_data = {root_holdoff, 1'b0, gap_count};

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (gap_count == $past(wr_data[GAP_W-1:0])
                   && root_holdoff == $past(wr_data[RHB_POS])));  // R2
    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[IBR_POS]) |=> bus_reset_req);  // R3
    AST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[IBR_POS]) |=> !bus_reset_req);  // R3
    AST_PKT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (pcfg_rx_valid || pcfg_tx_valid) && pcfg_t)
            |=> (gap_count == $past(pcfg_gap)));  // R5
endmodule

// File: tb/tb_phy_gap_ctrl.sv
module tb_phy_gap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pcfg_rx_valid = 1'b0, pcfg_tx_valid = 1'b0;
    logic       pcfg_r = 1'b0, pcfg_rhb = 1'b0, pcfg_t = 1'b0;
    logic [5:0] pcfg_gap = '0;
    logic       brst_done = 1'b0;
    logic [5:0] gap_count;
    logic       root_holdoff, bus_reset_req;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    phy_gap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pcfg_rx_valid(pcfg_rx_valid), .pcfg_tx_valid(pcfg_tx_valid),
        .pcfg_r(pcfg_r), .pcfg_rhb(pcfg_rhb), .pcfg_t(pcfg_t), .pcfg_gap(pcfg_gap),
        .brst_done(brst_done), .gap_count(gap_count), .root_holdoff(root_holdoff),
        .bus_reset_req(bus_reset_req)
    );

    // Vector: [32:29] req, [28] wr, [27:20] wdata, [19] rx, [18] tx, [17] r, [16] rhb,
    // [15] t, [14:9] gap, [8] brst, [7:2] exp gap, [1] exp rhb, [0] exp req
    function automatic logic [32:0] v(input logic [3:0] rq, input logic wr, input logic [7:0] wd,
        input logic rx, input logic tx, input logic r, input logic rh, input logic t,
        input logic [5:0] g, input logic br, input logic [5:0] eg, input logic er, input logic eq);
        return {rq, wr, wd, rx, tx, r, rh, t, g, br, eg, er, eq};
    endfunction

    localparam int NV = 17;
    localparam logic [32:0] VEC [NV] = '{
        v(4'd2, 1, 8'h85, 0,0,0,0,0, 6'd0,  0, 6'd5,  1, 0), // R2 write, strobe clear
        v(4'd8, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd5,  1, 0), // R8 first reset keeps
        v(4'd7, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd63, 1, 0), // R7 second bare reset
        v(4'd3, 1, 8'h4A, 0,0,0,0,0, 6'd0,  0, 6'd10, 0, 1), // R3 strobe write
        v(4'd8, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd10, 0, 0), // R8 own reset keeps value
        v(4'd5, 0, 8'h00, 1,0,1,1,1, 6'd20, 0, 6'd20, 1, 0), // R5 received packet
        v(4'd8, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd20, 1, 0), // R8
        v(4'd5, 0, 8'h00, 0,1,0,0,1, 6'd33, 0, 6'd33, 1, 0), // R5 transmitted, R=0
        v(4'd8, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd33, 1, 0), // R8
        v(4'd6, 0, 8'h00, 0,1,1,0,0, 6'd7,  0, 6'd33, 0, 0), // R6 T=0 packet
        v(4'd6, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd63, 0, 0), // R6 history kept
        v(4'd9, 0, 8'h00, 1,0,0,0,1, 6'd12, 1, 6'd12, 0, 0), // R9 update + reset
        v(4'd9, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd63, 0, 0), // R9 next reset forces
        v(4'd10,1, 8'h11, 1,0,1,1,1, 6'd40, 0, 6'd17, 0, 0), // R10 write wins
        v(4'd8, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd17, 0, 0), // R8
        v(4'd9, 1, 8'h51, 0,0,0,0,0, 6'd0,  1, 6'd17, 0, 1), // R9 strobe write + reset
        v(4'd7, 0, 8'h00, 0,0,0,0,0, 6'd0,  1, 6'd63, 0, 0)  // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; pcfg_rx_valid = 0; pcfg_tx_valid = 0;
        pcfg_r = 0; pcfg_rhb = 0; pcfg_t = 0; pcfg_gap = 6'h2A; brst_done = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : main
        do_reset();
        @(negedge clk);
        chk("R1 gap", 32'(gap_count), 32'd63);
        chk("R1 rhb", 32'(root_holdoff), 32'd0);
        chk("R1 req", 32'(bus_reset_req), 32'd0);
        chk("R1 rd", 32'(rd_data), 32'h3F);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] e;
            string tg;
            e = VEC[i];
            wr_en = e[28]; wr_data = e[27:20]; pcfg_rx_valid = e[19]; pcfg_tx_valid = e[18];
            pcfg_r = e[17]; pcfg_rhb = e[16]; pcfg_t = e[15]; pcfg_gap = e[14:9];
            brst_done = e[8];
            @(posedge clk);
            @(negedge clk);
            idle();
            tg = $sformatf("R%0d vec%0d", e[32:29], i);
            chk({tg, " gap"}, 32'(gap_count), 32'(e[7:2]));
            chk({tg, " rhb"}, 32'(root_holdoff), 32'(e[1]));
            chk({tg, " req"}, 32'(bus_reset_req), 32'(e[0]));
            chk({tg, " R4 rd"}, 32'(rd_data), 32'({e[1], 1'b0, e[7:2]}));
        end

        // R3: the request lasts one cycle only
        wr_en = 1; wr_data = 8'hC9;
        @(negedge clk); idle();
        chk("R3 pulse high", 32'(bus_reset_req), 32'd1);
        chk("R4 rd strobe bit", 32'(rd_data), 32'h89);
        @(negedge clk);
        chk("R3 pulse low", 32'(bus_reset_req), 32'd0);

        // R1: reset in mid-run restores defaults
        do_reset();
        @(negedge clk);
        chk("R1 rerun rd", 32'(rd_data), 32'h3F);
        chk("R1 rerun req", 32'(bus_reset_req), 32'd0);

        // R5: packet with R=1 and T=0 changes only the holdoff flag
        pcfg_tx_valid = 1; pcfg_r = 1; pcfg_rhb = 1; pcfg_t = 0; pcfg_gap = 6'd3;
        @(negedge clk); idle();
        chk("R5 R-only rd", 32'(rd_data), 32'hBF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule